// File: doc/BRIEF.md
# Priority-Ordered Layer Compositor

This block merges four time-aligned pixel streams, such as video planes and graphics overlays, into one output stream for each display output. A programmable priority on each layer sets its stacking order. Layers are blended from the back to the front, using the 8-bit alpha that each layer carries on every pixel. Each output has its own visibility mask, so one layer can appear on one output and be absent from another. Where no visible layer contributes, the output shows a programmable background colour. These settings support full-screen video, graphics over video, video inside graphics, and picture-in-picture.

All layers share one valid strobe and one pair of frame-start and line-end markers. The priority, visibility and background settings are captured only on a frame-start pixel, so a change in mid-frame never tears the picture. The output is RGB888 and appears after a fixed pipeline delay, together with the markers, which are delayed by the same amount.

Top module: `layer_compositor`

## Requirements
- R1: Layers are drawn in ascending order of their 2-bit priority (layer l uses `layer_prio_i[2l+1:2l]`), so a higher value lies nearer the viewer. When two layers have equal priority, the layer with the lower index is drawn first, which places it behind.
- R2: Each visible layer is blended over the colour accumulated so far. For every channel the result is (a*top + (255-a)*below + 127)/255, with integer division. A layer pixel sits at `layer_pix_i[32l+31:32l]` as A[31:24], R[23:16], G[15:8] and B[7:0]. An output colour has R in [23:16], G in [15:8] and B in [7:0].
- R3: A visible pixel with alpha 255 replaces the accumulated colour with its own RGB.
- R4: A pixel with alpha 0 leaves the accumulated colour unchanged.
- R5: Bit `o*4+l` of `out_vis_i` shows layer l on output o. A hidden layer has no effect on that output and does not change what the other outputs show.
- R6: Blending starts from `bg_rgb_i`. If no layer is visible, the output equals the background colour.
- R7: The priority, visibility and background inputs are captured only on a cycle with `pix_valid_i && sof_i`, and they apply from that pixel onwards. Changes on any other cycle have no effect.
- R8: Each input pixel appears on the outputs exactly NUM_LAYERS+1 cycles later (5 with the defaults). `pix_valid_o`, `sof_o` and `eol_o` are delayed by the same number of cycles.
- R9: While reset is held, `pix_valid_o`, `sof_o` and `eol_o` are low and `out_rgb_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | The input pixels on this cycle are valid |
| sof_i | input | 1 | Frame-start marker |
| eol_i | input | 1 | Line-end marker |
| layer_pix_i | input | NUM_LAYERS*32 | One ARGB8888 pixel per layer |
| layer_prio_i | input | NUM_LAYERS*PRIO_W | Display-order priority of each layer |
| out_vis_i | input | NUM_OUTS*NUM_LAYERS | Visibility of each layer on each output |
| bg_rgb_i | input | 24 | Background colour |
| pix_valid_o | output | 1 | The output pixels on this cycle are valid |
| sof_o | output | 1 | Delayed frame-start marker |
| eol_o | output | 1 | Delayed line-end marker |
| out_rgb_o | output | NUM_OUTS*24 | One composited RGB888 pixel per output |

## Verification
Checks run on every cycle: the computed drawing order stays strictly ordered by priority and then by index, each blend stage forwards its markers with one cycle of delay, alpha 255 replaces the colour, an alpha-0 or hidden pixel leaves it untouched, and the held settings change only on a frame-start pixel. Other behaviour can be shown only by the bench's scenarios. This covers the rounded value of partial blends, the full back-to-front result across all four layers, how masks that differ per output separate the outputs, the fallback to the background colour, and the total delay counted from the input to the port.

// File: rtl/comp_pkg.sv
package comp_pkg;
  localparam int unsigned PIX_W = 32;
  localparam int unsigned RGB_W = 24;

  // one channel of a rounded alpha mix, result always fits 8 bits
  function automatic logic [7:0] mix8(input logic [7:0] a,
                                      input logic [7:0] top,
                                      input logic [7:0] bot);
    logic [16:0] sum;
    sum = 17'(a) * 17'(top) + 17'(8'd255 - a) * 17'(bot) + 17'd127;
    return 8'(sum / 17'd255);
  endfunction
endpackage

// File: rtl/comp_cfg_shadow.sv
module comp_cfg_shadow #(
  parameter int unsigned NL = 4,
  parameter int unsigned NO = 2,
  parameter int unsigned PW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NL*PW-1:0] prio_i,
  input  logic [NO*NL-1:0] vis_i,
  input  logic [23:0]      bg_i,
  output logic [NL*PW-1:0] prio_o,
  output logic [NO*NL-1:0] vis_o,
  output logic [23:0]      bg_o
);
  logic [NL*PW-1:0] prio_q;
  logic [NO*NL-1:0] vis_q;
  logic [23:0]      bg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      vis_q  <= '0;
      bg_q   <= '0;
    end else if (load_i) begin
      prio_q <= prio_i;
      vis_q  <= vis_i;
      bg_q   <= bg_i;
    end
  end

  // the frame-start pixel already uses the new settings
  assign prio_o = load_i ? prio_i : prio_q;
  assign vis_o  = load_i ? vis_i  : vis_q;
  assign bg_o   = load_i ? bg_i   : bg_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable({prio_q, vis_q, bg_q})); // R7
endmodule

// File: rtl/comp_order.sv
module comp_order #(
  parameter int unsigned NL = 4,
  parameter int unsigned PW = 2,
  localparam int unsigned IW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic [NL*PW-1:0] prio_i,
  output logic [NL*IW-1:0] slot_o
);
  // rank = number of layers drawn before this one; slot[rank] = layer
  always_comb begin
    slot_o = '0;
    for (int i = 0; i < NL; i++) begin
      int unsigned rank;
      rank = 0;
      for (int j = 0; j < NL; j++) begin
        if ((prio_i[j*PW +: PW] < prio_i[i*PW +: PW]) ||
            ((prio_i[j*PW +: PW] == prio_i[i*PW +: PW]) && (j < i)))
          rank = rank + 1;
      end
      slot_o[rank*IW +: IW] = IW'(i);
    end
  end
endmodule

// File: rtl/comp_blend_stage.sv
module comp_blend_stage import comp_pkg::*; #(
  parameter int unsigned NL    = 4,
  parameter int unsigned NO    = 2,
  parameter int unsigned IW    = 2,
  parameter int unsigned STAGE = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eol_i,
  input  logic [NL*32-1:0] pix_i,
  input  logic [NL*IW-1:0] slot_i,
  input  logic [NO*NL-1:0] vis_i,
  input  logic [NO*24-1:0] acc_i,
  output logic             valid_o,
  output logic             sof_o,
  output logic             eol_o,
  output logic [NL*32-1:0] pix_o,
  output logic [NL*IW-1:0] slot_o,
  output logic [NO*NL-1:0] vis_o,
  output logic [NO*24-1:0] acc_o
);
  logic [IW-1:0]    sel;
  logic [31:0]      top;
  logic [NO-1:0]    shown;
  logic [NO*24-1:0] acc_d;

  assign sel = slot_i[STAGE*IW +: IW];
  assign top = pix_i[sel*32 +: 32];

  for (genvar o = 0; o < NO; o++) begin : g_out
    assign shown[o] = vis_i[o*NL + int'(sel)];

    always_comb begin
      acc_d[o*24 +: 24] = acc_i[o*24 +: 24];
      if (shown[o] && (top[31:24] != 8'd0)) begin
        for (int c = 0; c < 3; c++)
          acc_d[o*24 + c*8 +: 8] = mix8(top[31:24], top[c*8 +: 8], acc_i[o*24 + c*8 +: 8]);
      end
    end

    AST_FULL_ALPHA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && shown[o] && (top[31:24] == 8'hff)
      |=> acc_o[o*24 +: 24] == $past(top[23:0])); // R3
    AST_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && (!shown[o] || (top[31:24] == 8'h00))
      |=> acc_o[o*24 +: 24] == $past(acc_i[o*24 +: 24])); // R4
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      eol_o   <= 1'b0;
      pix_o   <= '0;
      slot_o  <= '0;
      vis_o   <= '0;
      acc_o   <= '0;
    end else begin
      valid_o <= valid_i;
      sof_o   <= sof_i;
      eol_o   <= eol_i;
      pix_o   <= pix_i;
      slot_o  <= slot_i;
      vis_o   <= vis_i;
      acc_o   <= acc_d;
    end
  end

  AST_MARK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> {valid_o, sof_o, eol_o} == $past({valid_i, sof_i, eol_i})); // R8
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor import comp_pkg::*; #(
  parameter int unsigned NUM_LAYERS = 4,
  parameter int unsigned NUM_OUTS   = 2,
  parameter int unsigned PRIO_W     = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           pix_valid_i,
  input  logic                           sof_i,
  input  logic                           eol_i,
  input  logic [NUM_LAYERS*32-1:0]       layer_pix_i,
  input  logic [NUM_LAYERS*PRIO_W-1:0]   layer_prio_i,
  input  logic [NUM_OUTS*NUM_LAYERS-1:0] out_vis_i,
  input  logic [23:0]                    bg_rgb_i,
  output logic                           pix_valid_o,
  output logic                           sof_o,
  output logic                           eol_o,
  output logic [NUM_OUTS*24-1:0]         out_rgb_o
);
  localparam int unsigned NL = NUM_LAYERS;
  localparam int unsigned NO = NUM_OUTS;
  localparam int unsigned PW = PRIO_W;
  localparam int unsigned IW = (NL > 1) ? $clog2(NL) : 1;

  logic             cfg_load;
  logic [NL*PW-1:0] eff_prio;
  logic [NO*NL-1:0] eff_vis;
  logic [23:0]      eff_bg;
  logic [NL*IW-1:0] slot_c;

  assign cfg_load = pix_valid_i && sof_i;

  comp_cfg_shadow #(.NL(NL), .NO(NO), .PW(PW)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load),
    .prio_i (layer_prio_i),
    .vis_i  (out_vis_i),
    .bg_i   (bg_rgb_i),
    .prio_o (eff_prio),
    .vis_o  (eff_vis),
    .bg_o   (eff_bg)
  );

  comp_order #(.NL(NL), .PW(PW)) u_order (
    .prio_i (eff_prio),
    .slot_o (slot_c)
  );

  // stage 0: capture pixels, drawing order and background seed
  logic             s0_valid, s0_sof, s0_eol;
  logic [NL*32-1:0] s0_pix;
  logic [NL*IW-1:0] s0_slot;
  logic [NO*NL-1:0] s0_vis;
  logic [NO*24-1:0] s0_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_valid <= 1'b0;
      s0_sof   <= 1'b0;
      s0_eol   <= 1'b0;
      s0_pix   <= '0;
      s0_slot  <= '0;
      s0_vis   <= '0;
      s0_acc   <= '0;
    end else begin
      s0_valid <= pix_valid_i;
      s0_sof   <= sof_i;
      s0_eol   <= eol_i;
      s0_pix   <= layer_pix_i;
      s0_slot  <= slot_c;
      s0_vis   <= eff_vis;
      s0_acc   <= {NO{eff_bg}};
    end
  end

  logic             st_valid [NL+1];
  logic             st_sof   [NL+1];
  logic             st_eol   [NL+1];
  logic [NL*32-1:0] st_pix   [NL+1];
  logic [NL*IW-1:0] st_slot  [NL+1];
  logic [NO*NL-1:0] st_vis   [NL+1];
  logic [NO*24-1:0] st_acc   [NL+1];

  assign st_valid[0] = s0_valid;
  assign st_sof[0]   = s0_sof;
  assign st_eol[0]   = s0_eol;
  assign st_pix[0]   = s0_pix;
  assign st_slot[0]  = s0_slot;
  assign st_vis[0]   = s0_vis;
  assign st_acc[0]   = s0_acc;

  // one stage per drawing slot, back to front
  for (genvar k = 0; k < NL; k++) begin : g_stage
    comp_blend_stage #(.NL(NL), .NO(NO), .IW(IW), .STAGE(k)) u_blend (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (st_valid[k]),
      .sof_i   (st_sof[k]),
      .eol_i   (st_eol[k]),
      .pix_i   (st_pix[k]),
      .slot_i  (st_slot[k]),
      .vis_i   (st_vis[k]),
      .acc_i   (st_acc[k]),
      .valid_o (st_valid[k+1]),
      .sof_o   (st_sof[k+1]),
      .eol_o   (st_eol[k+1]),
      .pix_o   (st_pix[k+1]),
      .slot_o  (st_slot[k+1]),
      .vis_o   (st_vis[k+1]),
      .acc_o   (st_acc[k+1])
    );
  end

  assign pix_valid_o = st_valid[NL];
  assign sof_o       = st_sof[NL];
  assign eol_o       = st_eol[NL];
  assign out_rgb_o   = st_acc[NL];

  // strict order by (priority, index) also proves the slots form a permutation
  for (genvar k = 0; k + 1 < NL; k++) begin : g_ord_chk
    AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      {eff_prio[slot_c[k*IW +: IW]*PW +: PW], slot_c[k*IW +: IW]} <
      {eff_prio[slot_c[(k+1)*IW +: IW]*PW +: PW], slot_c[(k+1)*IW +: IW]}); // R1
  end
endmodule

// File: tb/layer_compositor_bench.sv
module layer_compositor_bench;
  localparam int NL  = 4;
  localparam int NO  = 2;
  localparam int LAT = NL + 1;

  typedef struct packed {
    logic [127:0] pix;
    logic [7:0]   prio;
    logic [7:0]   vis;
    logic [23:0]  bg;
  } vec_t;

  // pixels are {layer3, layer2, layer1, layer0}; expected colours come from ref_out
  localparam vec_t VECS [8] = '{
    '{128'h80FFFFFF_80FFFFFF_80FFFFFF_80FFFFFF, 8'hE4, 8'h00, 24'h123456}, // R6 nothing shown
    '{128'h00000000_00000000_00000000_FF102030, 8'h00, 8'h11, 24'h000000}, // R3 single opaque
    '{128'h00000000_00000000_80FFFFFF_FFAABBCC, 8'h04, 8'hFF, 24'h000000}, // R2 half over opaque
    '{128'hFF444444_FF333333_FF222222_FF111111, 8'h00, 8'hFF, 24'h000000}, // R1 ties
    '{128'hFF444444_FF333333_FF222222_FF111111, 8'h93, 8'hFF, 24'h000000}, // R1 layer0 on top
    '{128'h00000000_FF0000FF_FF00FF00_FFFF0000, 8'h00, 8'h42, 24'h000000}, // R5 split outputs
    '{128'h00FFFFFF_00000000_00000000_FF405060, 8'hC0, 8'hFF, 24'h000000}, // R4 alpha 0 on top
    '{128'h01FFFFFF_7F808080_C0204060_40C08040, 8'hE4, 8'hF7, 24'h102030}  // R2 full stack
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0, sof = 1'b0, eol = 1'b0;
  logic [127:0]  pix = '0;
  logic [7:0]    prio = '0;
  logic [7:0]    vis = '0;
  logic [23:0]   bg = '0;
  logic          valid_o, sof_o, eol_o;
  logic [47:0]   rgb_o;
  int            total = 0;
  int            bad = 0;

  always #10 clk = ~clk;

  layer_compositor u_layer_compositor (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pix_valid_i  (valid),
    .sof_i        (sof),
    .eol_i        (eol),
    .layer_pix_i  (pix),
    .layer_prio_i (prio),
    .out_vis_i    (vis),
    .bg_rgb_i     (bg),
    .pix_valid_o  (valid_o),
    .sof_o        (sof_o),
    .eol_o        (eol_o),
    .out_rgb_o    (rgb_o)
  );

  function automatic int mix_ref(input int a, input int t, input int b);
    return (a * t + (255 - a) * b + 127) / 255;
  endfunction

  // back to front: priority value ascending, equal values by index ascending
  function automatic logic [23:0] ref_out(input vec_t v, input int o);
    logic [23:0] acc;
    acc = v.bg;
    for (int p = 0; p < 4; p++) begin
      for (int l = 0; l < NL; l++) begin
        if (int'(v.prio[2*l +: 2]) == p && v.vis[o*NL + l]) begin
          logic [31:0] px;
          px = v.pix[32*l +: 32];
          for (int c = 0; c < 3; c++)
            acc[8*c +: 8] = 8'(mix_ref(int'(px[31:24]), int'(px[8*c +: 8]), int'(acc[8*c +: 8])));
        end
      end
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input vec_t v, input logic s, input logic e);
    @(negedge clk);
    pix = v.pix; prio = v.prio; vis = v.vis; bg = v.bg;
    valid = 1'b1; sof = s; eol = e;
    @(negedge clk);
    valid = 1'b0; sof = 1'b0; eol = 1'b0;
    repeat (LAT - 1) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t alt;
    repeat (3) @(negedge clk);
    check("R9 reset", {45'd0, valid_o, sof_o, eol_o}, 48'd0);
    check("R9 reset rgb", rgb_o, 48'd0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      send(VECS[i], 1'b1, 1'b0);
      check($sformatf("R2 vec%0d out0", i), {24'd0, rgb_o[23:0]},  {24'd0, ref_out(VECS[i], 0)});
      check($sformatf("R5 vec%0d out1", i), {24'd0, rgb_o[47:24]}, {24'd0, ref_out(VECS[i], 1)});
    end

    // R8 latency and markers
    @(negedge clk);
    pix = VECS[1].pix; prio = VECS[1].prio; vis = VECS[1].vis; bg = VECS[1].bg;
    valid = 1'b1; sof = 1'b1; eol = 1'b1;
    for (int c = 1; c <= LAT; c++) begin
      @(negedge clk);
      valid = 1'b0; sof = 1'b0; eol = 1'b0;
      check($sformatf("R8 markers cycle %0d", c), {45'd0, valid_o, sof_o, eol_o},
            (c == LAT) ? 48'd7 : 48'd0);
    end
    check("R8 data at latency", rgb_o, {24'h102030, 24'h102030});

    // R7 settings held until the next frame start
    send(VECS[2], 1'b1, 1'b0);
    alt = VECS[2];
    alt.prio = 8'h01; alt.vis = 8'h00; alt.bg = 24'hFFFFFF;
    send(alt, 1'b0, 1'b0);
    check("R7 mid-frame change ignored", rgb_o, {ref_out(VECS[2], 1), ref_out(VECS[2], 0)});
    send(alt, 1'b1, 1'b0);
    check("R7 frame start applies", rgb_o, {24'hFFFFFF, 24'hFFFFFF});

    // R3 alpha 255 over background, R4 alpha 0 only leaves background
    alt = '{128'h00000000_00000000_00000000_FF0A0B0C, 8'h00, 8'h01, 24'h777777};
    send(alt, 1'b1, 1'b0);
    check("R3 opaque out0", {24'd0, rgb_o[23:0]}, {24'd0, 24'h0A0B0C});
    check("R5 hidden on out1", {24'd0, rgb_o[47:24]}, {24'd0, 24'h777777});
    alt.pix = 128'h00000000_00000000_00000000_000A0B0C;
    send(alt, 1'b1, 1'b0);
    check("R4 alpha zero", {24'd0, rgb_o[23:0]}, {24'd0, 24'h777777});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule